// File: doc/BRIEF.md
# Masked Sticky Error Status Flag

This block gathers error events from the detectors of a received video stream and holds them in an eight-bit status register, one bit per error source. Each source has a mask bit. A source is monitored only while its mask bit is high, and a source that is not monitored is never captured. A single active-low flag output tells the rest of the system whether any monitored error has been seen since the last clear. The flag is registered in the parallel data clock domain.

Captured errors are sticky. They are cleared in two ways: by a one-cycle start-of-frame/field pulse, or by a read of the status register through a small register port. That read returns the value the register held before the clear. If an error event arrives in the same cycle as a clear, the event wins and its bit remains set.

The register port has one read strobe, one write strobe and a one-bit select. Select 0 addresses the status register, which is read-only. Select 1 addresses the mask register, which can be read and written. The host-side serial framing, the detectors themselves and any test access logic lie outside this block.

Top module: `err_status_flag`

## Requirements
- R1: After reset the flag output is high, the status register is all zeros, and the mask register is all ones, so every source is monitored.
- R2: An error pulse on a source whose mask bit is high sets that status bit at the next clock edge. The bit then stays set until a clear occurs.
- R3: An error pulse on a source whose mask bit is low never sets its status bit.
- R4: The flag output is registered and equals the inverse of the OR of (status AND mask), as those were one clock earlier. It is therefore low exactly when a monitored status bit was set in the previous cycle.
- R5: A start-of-frame/field pulse clears every status bit at the next clock edge.
- R6: A read strobe with select 0 returns the current status value on the read data bus in the same cycle, and clears the status register at the next clock edge.
- R7: A monitored error pulse that arrives in the same cycle as a clear (frame start or status read) leaves its status bit set after that edge.
- R8: A write strobe with select 1 loads the write data into the mask register at the next edge. A read strobe with select 1 returns the mask and does not clear the status. An error pulse in the same cycle as a mask write is judged against the old mask.
- R9: A write strobe with select 0 has no effect on the status register or on the flag.
- R10: The read data bus is zero in every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel data clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_evt_i | input | NUM_SRC | One-cycle error event pulses, one per source |
| frame_start_i | input | 1 | One-cycle start of frame or field pulse |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 status, 1 mask |
| reg_wdata_i | input | DATA_W | Write data for the mask register |
| reg_rdata_o | output | DATA_W | Read data, valid in the cycle of the read strobe |
| err_flag_n_o | output | 1 | Active-low registered error flag |

## Verification
The assertions assume that error pulses, frame starts and strobes are sampled only at clock edges. They also assume that a clear behaves the same whether it comes from a frame start, a status read or both at once. No assumption is made on how often events arrive. The random stimulus drives every input just after the falling edge, so that each input is stable across the rising edge. It keeps frame starts and register accesses sparse so that sticky bits build up between clears. Directed cases then force the collisions: an event together with a clear, and an event together with a mask write.

// File: rtl/efl_pkg.sv
package efl_pkg;
   typedef enum logic {
      SEL_STATUS = 1'b0,
      SEL_MASK   = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/efl_mask_reg.sv
module efl_mask_reg #(
   parameter int NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_i,
   input  logic [NUM_SRC-1:0] wdata_i,
   output logic [NUM_SRC-1:0] mask_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mask_o <= '1;
      else if (wr_i) mask_o <= wdata_i;
   end

   // R8
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(mask_o));
endmodule

// File: rtl/efl_status_cap.sv
module efl_status_cap #(
   parameter int NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic [NUM_SRC-1:0] mask_i,
   input  logic               clr_i,
   output logic [NUM_SRC-1:0] status_o
);
   logic [NUM_SRC-1:0] hit;
   logic [NUM_SRC-1:0] kept;

   assign hit  = evt_i & mask_i;
   assign kept = clr_i ? '0 : status_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_o <= '0;
      else        status_o <= kept | hit;
   end

   // R2
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> (($past(status_o) & ~status_o) == '0));
   // R3
   masked_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status_o & ~$past(status_o) & ~$past(mask_i)) == '0));
   // R5
   clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && (evt_i == '0)) |=> (status_o == '0));
   // R7
   event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt_i & mask_i)) |=> ((status_o & $past(evt_i & mask_i)) == $past(evt_i & mask_i)));
endmodule

// File: rtl/efl_flag_out.sv
module efl_flag_out #(
   parameter int NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] status_i,
   input  logic [NUM_SRC-1:0] mask_i,
   output logic               flag_n_o
);
   logic any_err;
   assign any_err = |(status_i & mask_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_n_o <= 1'b1;
      else        flag_n_o <= ~any_err;
   end

   // R4
   flag_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (flag_n_o == ~|($past(status_i) & $past(mask_i))));
endmodule

// File: rtl/err_status_flag.sv
module err_status_flag
   import efl_pkg::*;
#(
   parameter int NUM_SRC = 8,
   parameter int DATA_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] err_evt_i,
   input  logic               frame_start_i,
   input  logic               reg_rd_i,
   input  logic               reg_wr_i,
   input  logic               reg_sel_i,
   input  logic [DATA_W-1:0]  reg_wdata_i,
   output logic [DATA_W-1:0]  reg_rdata_o,
   output logic               err_flag_n_o
);
   localparam int PAD_W = DATA_W - NUM_SRC;

   if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_cfg
      $error("err_status_flag: NUM_SRC must lie in 1..DATA_W");
   end

   reg_sel_e           sel;
   logic               sel_status;
   logic               status_rd;
   logic               mask_wr;
   logic               clr;
   logic [NUM_SRC-1:0] mask_q;
   logic [NUM_SRC-1:0] status_q;
   logic [NUM_SRC-1:0] rd_mux;

   assign sel        = reg_sel_e'(reg_sel_i);
   assign sel_status = (sel == SEL_STATUS);
   assign status_rd  = reg_rd_i & sel_status;
   assign mask_wr    = reg_wr_i & ~sel_status;
   assign clr        = frame_start_i | status_rd;

   efl_mask_reg #(.NUM_SRC(NUM_SRC)) i_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (mask_wr),
      .wdata_i (reg_wdata_i[NUM_SRC-1:0]),
      .mask_o  (mask_q)
   );

   efl_status_cap #(.NUM_SRC(NUM_SRC)) i_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (err_evt_i),
      .mask_i   (mask_q),
      .clr_i    (clr),
      .status_o (status_q)
   );

   efl_flag_out #(.NUM_SRC(NUM_SRC)) i_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .status_i (status_q),
      .mask_i   (mask_q),
      .flag_n_o (err_flag_n_o)
   );

   assign rd_mux = !reg_rd_i ? '0 : (sel_status ? status_q : mask_q);

   if (PAD_W > 0) begin : g_pad
      assign reg_rdata_o = {{PAD_W{1'b0}}, rd_mux};
   end else begin : g_nopad
      assign reg_rdata_o = rd_mux;
   end

   // R10
   rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd_i |-> (reg_rdata_o == '0));
endmodule

// File: tb/test_err_status_flag.sv
module test_err_status_flag;
   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] evt = '0;
   logic         sof = 1'b0;
   logic         rd = 1'b0;
   logic         wr = 1'b0;
   logic         sel = 1'b0;
   logic [N-1:0] wd = '0;
   logic [N-1:0] rdata;
   logic         flag_n;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [N-1:0] m_status;
   logic [N-1:0] m_mask;
   logic         m_flag;
   logic [N-1:0] last_rd;

   always #10 clk = ~clk;

   err_status_flag #(.NUM_SRC(N), .DATA_W(N)) i_err_status_flag (
      .clk           (clk),
      .rst_n         (rst_n),
      .err_evt_i     (evt),
      .frame_start_i (sof),
      .reg_rd_i      (rd),
      .reg_wr_i      (wr),
      .reg_sel_i     (sel),
      .reg_wdata_i   (wd),
      .reg_rdata_o   (rdata),
      .err_flag_n_o  (flag_n)
   );

   function automatic logic [N-1:0] next_status(input logic [N-1:0] st, input logic [N-1:0] mk,
                                                input logic [N-1:0] ev, input logic clear);
      return (clear ? '0 : st) | (ev & mk);
   endfunction

   function automatic logic next_flag(input logic [N-1:0] st, input logic [N-1:0] mk);
      return ~|(st & mk);
   endfunction

   function automatic logic [N-1:0] exp_rdata(input logic r, input logic s,
                                              input logic [N-1:0] st, input logic [N-1:0] mk);
      if (!r) return '0;
      return s ? mk : st;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input logic [N-1:0] e, input logic f, input logic r, input logic w,
                      input logic s, input logic [N-1:0] d);
      logic clear;
      evt = e; sof = f; rd = r; wr = w; sel = s; wd = d;
      #5;
      last_rd = rdata;
      if (r) chk(s ? "R8 mask read" : "R6 status read", rdata, exp_rdata(r, s, m_status, m_mask));
      else   chk("R10 idle rdata", rdata, '0);
      @(posedge clk);
      clear   = f | (r & ~s);
      m_flag  = next_flag(m_status, m_mask);
      m_status = next_status(m_status, m_mask, e, clear);
      if (w && s) m_mask = d;
      @(negedge clk);
      evt = '0; sof = 1'b0; rd = 1'b0; wr = 1'b0; sel = 1'b0; wd = '0;
      chk("R4 flag", flag_n, m_flag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc('0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(20 * 150000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      int seed;
      seed = 1234;
      void'($urandom(seed));
      m_status = '0; m_mask = '1; m_flag = 1'b1; last_rd = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 flag after reset", flag_n, 1'b1);
      cyc('0, 1'b0, 1'b1, 1'b0, 1'b1, '0);
      chk("R1 mask after reset", last_rd, 8'hFF);
      cyc('0, 1'b0, 1'b1, 1'b0, 1'b0, '0);
      chk("R1 status after reset", last_rd, 8'h00);

      // R2: sticky capture and flag
      cyc(8'h08, 1'b0, 1'b0, 1'b0, 1'b0, '0);
      idle(3);
      chk("R2 flag low while held", flag_n, 1'b0);
      cyc('0, 1'b0, 1'b1, 1'b0, 1'b0, '0);
      chk("R6 read returns pre-clear", last_rd, 8'h08);
      cyc('0, 1'b0, 1'b1, 1'b0, 1'b0, '0);
      chk("R6 read cleared status", last_rd, 8'h00);
      idle(1);
      chk("R6 flag high after read clear", flag_n, 1'b1);

      // R3 / R8: masked sources ignored
      cyc('0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hF0);
      cyc(8'h0F, 1'b0, 1'b0, 1'b0, 1'b0, '0);
      idle(1);
      chk("R3 flag high for masked event", flag_n, 1'b1);
      cyc('0, 1'b0, 1'b1, 1'b0, 1'b1, '0);
      chk("R8 mask readback", last_rd, 8'hF0);
      cyc('0, 1'b0, 1'b1, 1'b0, 1'b0, '0);
      chk("R3 masked event not captured", last_rd, 8'h00);

      // R8: event with mask write uses old mask
      cyc(8'h01, 1'b0, 1'b0, 1'b1, 1'b1, 8'hFF);
      cyc('0, 1'b0, 1'b1, 1'b0, 1'b0, '0);
      chk("R8 event judged by old mask", last_rd, 8'h00);

      // R8: mask read does not clear status
      cyc(8'h40, 1'b0, 1'b0, 1'b0, 1'b0, '0);
      cyc('0, 1'b0, 1'b1, 1'b0, 1'b1, '0);
      cyc('0, 1'b0, 1'b1, 1'b0, 1'b0, '0);
      chk("R8 mask read keeps status", last_rd, 8'h40);

      // R9: write to status address ignored
      cyc('0, 1'b0, 1'b0, 1'b1, 1'b0, 8'hFF);
      idle(1);
      chk("R9 flag unaffected", flag_n, 1'b1);
      cyc('0, 1'b0, 1'b1, 1'b0, 1'b0, '0);
      chk("R9 status unaffected", last_rd, 8'h00);

      // R5: frame start clears
      cyc(8'h20, 1'b0, 1'b0, 1'b0, 1'b0, '0);
      cyc('0, 1'b1, 1'b0, 1'b0, 1'b0, '0);
      idle(1);
      chk("R5 flag high after frame start", flag_n, 1'b1);
      cyc('0, 1'b0, 1'b1, 1'b0, 1'b0, '0);
      chk("R5 status cleared", last_rd, 8'h00);

      // R7: event wins over clear
      cyc(8'h02, 1'b0, 1'b0, 1'b0, 1'b0, '0);
      cyc(8'h10, 1'b1, 1'b0, 1'b0, 1'b0, '0);
      cyc(8'h80, 1'b0, 1'b1, 1'b0, 1'b0, '0);
      chk("R7 event kept over frame clear", last_rd, 8'h10);
      cyc('0, 1'b0, 1'b1, 1'b0, 1'b0, '0);
      chk("R7 event kept over read clear", last_rd, 8'h80);

      // random mix
      for (int i = 0; i < 4000; i++) begin
         logic [N-1:0] e;
         logic f, r, w, s;
         e = (($urandom % 4) == 0) ? N'($urandom) & N'($urandom) : '0;
         f = (($urandom % 16) == 0);
         r = (($urandom % 8) == 0);
         w = (($urandom % 12) == 0);
         s = $urandom % 2;
         cyc(e, f, r, w, s, N'($urandom));
      end

      finish_run();
   end
endmodule